// File: doc/BRIEF.md
# UART Receive/Transmit Status and Interrupt Core

This block sits between the serial engines of a UART and the host register port. On the receive side it keeps a queue of incoming characters. Each entry holds the data byte and three error flags: parity, framing and break. On the transmit side it counts the bytes waiting to be sent and watches whether the shift register is still busy. From this state it builds an eight-bit line status word, three interrupt conditions and a single interrupt line. The conditions are receive fill at or above a trigger, transmit space above a trigger, and line errors. An external modem-change request can also raise the interrupt.

The host sees five registers, selected by `regSel`:
- 0: data. A read pops the receive head. A write queues one transmit byte.
- 1: interrupt enable.
- 2: interrupt identification, read only.
- 3: FIFO control.
- 4: line status. A read clears the overrun flag.

After reset the block is in single-entry (non-FIFO) mode with every interrupt disabled, so it can be used purely by polling. Interrupts are level conditions. They drop by themselves as fill levels move.

Top module: `uart_stat_irq`

## Requirements
- R1: Line status bit 0 is 1 in the cycle after a character is offered on the receive push input, and it returns to 0 only when the receive queue is empty.
- R2: With FIFO mode on and enable bit 0 set, the interrupt output is 1 and the identification reads 0x04 while the receive fill is at or above the selected trigger. Both drop once a read takes the fill below the trigger.
- R3: A character offered while the receive queue is full sets line status bit 1. With enable bit 2 set, this raises the interrupt with identification 0x06 in the next cycle. A read of the line status register returns the bit as 1 and then clears it.
- R4: A character offered to a full receive queue is discarded, and the stored characters are read out unchanged and in order.
- R5: Line status bits 2, 3 and 4 give the parity, framing and break flags of the character at the queue head, and are 0 when the queue is empty.
- R6: Line status bit 7 is 1 while any stored character carries an error flag. While it is 1 and enable bit 2 is set, the interrupt stays asserted with identification 0x06.
- R7: Line status bit 5 is 1 when the transmit queue is empty. Bit 6 is 1 when the transmit queue is empty and `txShiftBusy` is 0.
- R8: With enable bit 1 set, the transmit-ready condition holds in FIFO mode while free transmit space exceeds the trigger, and in non-FIFO mode while the transmit queue is empty. If the condition already holds when the bit is set, the interrupt follows at once.
- R9: The enable register uses bit 0 for receive data, bit 1 for transmit ready, bit 2 for line status and bit 3 for `modemReq`. It resets to 0. With no enabled condition the interrupt output is 0 and the identification reads 0x01.
- R10: Several pending causes report by priority: line status (0x06), then receive data (0x04), then transmit ready (0x02), then modem (0x00).
- R11: In the FIFO control register, bit 0 enables FIFO mode. Bits 5:4 choose a receive trigger of 8, 16, 56 or 60 entries. Bits 7:6 choose a transmit space trigger of 8, 16, 32 or 56 entries.
- R12: In non-FIFO mode each queue holds one entry, so a second received character before a read is an overrun, and the first character is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxPushValid | input | 1 | Receive shifter delivers one character |
| rxPushData | input | 8 | Received byte |
| rxPushPar | input | 1 | Parity error flag of the character |
| rxPushFrm | input | 1 | Framing error flag of the character |
| rxPushBrk | input | 1 | Break flag of the character |
| txPop | input | 1 | Transmit shifter takes one byte from the queue |
| txShiftBusy | input | 1 | Transmit shift register holds a character |
| modemReq | input | 1 | Pending modem-change request |
| regSel | input | 3 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects at the clock edge) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| irqOut | output | 1 | Interrupt request |

## Verification
An error counter that drifts from the real number of flagged entries shows up as a status bit 7 that stays set, or drops too early, once the queue drains past the flagged character. The line-status interrupt follows it in the same cycle. A wrong fill count moves the receive or transmit interrupt edge by one push or pop away from its trigger, so each trigger is tested on both sides of the threshold. A head-pointer fault appears at the very next data read, as a wrong byte or as error flags attached to the wrong character.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

  typedef struct packed {
    logic rxPop;
    logic txPush;
  } ctlStrobe_t;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxEntry_t;

  localparam logic [3:0] ID_NONE   = 4'b0001;
  localparam logic [3:0] ID_LINE   = 4'b0110;
  localparam logic [3:0] ID_RXDATA = 4'b0100;
  localparam logic [3:0] ID_TXRDY  = 4'b0010;
  localparam logic [3:0] ID_MODEM  = 4'b0000;

  localparam logic [2:0] SEL_DATA  = 3'd0;
  localparam logic [2:0] SEL_IER   = 3'd1;
  localparam logic [2:0] SEL_IDENT = 3'd2;
  localparam logic [2:0] SEL_FCTL  = 3'd3;
  localparam logic [2:0] SEL_LSR   = 3'd4;

  function automatic logic entryBad(input rxEntry_t e);
    return e.par | e.frm | e.brk;
  endfunction

endpackage

// File: rtl/uart_stat_dp.sv
module uart_stat_dp
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoMode,
  input  ctlStrobe_t    strobe,
  input  logic          rxPushValid,
  input  rxEntry_t      rxPushEntry,
  input  logic          txPop,
  output rxEntry_t      rxHead,
  output logic [CW-1:0] rxCount,
  output logic [CW-1:0] rxErrCount,
  output logic [CW-1:0] txCount,
  output logic          rxDrop
);

  localparam logic [CW-1:0] FULL_CAP = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  rxEntry_t      mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] capacity;
  logic          rxFull, popOk, pushOk;
  logic          txPushOk, txPopOk;
  logic          errIn, errOut;

  assign capacity = fifoMode ? FULL_CAP : CW'(1);
  assign rxFull   = rxCount >= capacity;
  assign popOk    = strobe.rxPop && (rxCount != '0);
  assign pushOk   = rxPushValid && (!rxFull || popOk);
  assign rxDrop   = rxPushValid && !pushOk;
  assign rxHead   = mem[rdPtr];
  assign errIn    = pushOk && entryBad(rxPushEntry);
  assign errOut   = popOk && entryBad(rxHead);

  assign txPushOk = strobe.txPush && (txCount < capacity);
  assign txPopOk  = txPop && (txCount != '0);

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= rxPushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      rxCount    <= '0;
      rxErrCount <= '0;
      txCount    <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   rxCount <= rxCount + 1'b1;
        2'b01:   rxCount <= rxCount - 1'b1;
        default: rxCount <= rxCount;
      endcase
      case ({errIn, errOut})
        2'b10:   rxErrCount <= rxErrCount + 1'b1;
        2'b01:   rxErrCount <= rxErrCount - 1'b1;
        default: rxErrCount <= rxErrCount;
      endcase
      case ({txPushOk, txPopOk})
        2'b10:   txCount <= txCount + 1'b1;
        2'b01:   txCount <= txCount - 1'b1;
        default: txCount <= txCount;
      endcase
    end
  end

endmodule

// File: rtl/uart_stat_ctl.sv
module uart_stat_ctl
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    regSel,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [7:0]    regWdata,
  output logic [7:0]    regRdata,
  input  rxEntry_t      rxHead,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] rxErrCount,
  input  logic [CW-1:0] txCount,
  input  logic          rxDrop,
  input  logic          txShiftBusy,
  input  logic          modemReq,
  output ctlStrobe_t    strobe,
  output logic          fifoMode,
  output logic [7:0]    lsrBits,
  output logic [3:0]    ierBits,
  output logic [3:0]    irqId,
  output logic          irqOut
);

  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [7:0]    fctlReg;
  logic          overrun;
  logic [CW-1:0] rxTrig, txTrig, txFree;
  logic          hasData, errAny, txEmpty;
  logic          lineCond, rxCond, txCond, modemCond;

  assign fifoMode      = fctlReg[0];
  assign strobe.rxPop  = regRd && (regSel == SEL_DATA);
  assign strobe.txPush = regWr && (regSel == SEL_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ierBits <= '0;
      fctlReg <= '0;
      overrun <= 1'b0;
    end else begin
      if (regWr && regSel == SEL_IER)  ierBits <= regWdata[3:0];
      if (regWr && regSel == SEL_FCTL) fctlReg <= regWdata;
      if (rxDrop) overrun <= 1'b1;
      else if (regRd && regSel == SEL_LSR) overrun <= 1'b0;
    end
  end

  always_comb begin
    case (fctlReg[5:4])
      2'd0:    rxTrig = CW'(DEPTH / 8);
      2'd1:    rxTrig = CW'(DEPTH / 4);
      2'd2:    rxTrig = CW'(DEPTH - DEPTH / 8);
      default: rxTrig = CW'(DEPTH - DEPTH / 16);
    endcase
    case (fctlReg[7:6])
      2'd0:    txTrig = CW'(DEPTH / 8);
      2'd1:    txTrig = CW'(DEPTH / 4);
      2'd2:    txTrig = CW'(DEPTH / 2);
      default: txTrig = CW'(DEPTH - DEPTH / 8);
    endcase
  end

  assign txFree  = CAP - txCount;
  assign hasData = rxCount != '0;
  assign errAny  = rxErrCount != '0;
  assign txEmpty = txCount == '0;

  assign lsrBits = {errAny, txEmpty && !txShiftBusy, txEmpty,
                    hasData && rxHead.brk, hasData && rxHead.frm,
                    hasData && rxHead.par, overrun, hasData};

  assign lineCond  = ierBits[2] && (overrun || errAny);
  assign rxCond    = ierBits[0] && (fifoMode ? (rxCount >= rxTrig) : hasData);
  assign txCond    = ierBits[1] && (fifoMode ? (txFree > txTrig) : txEmpty);
  assign modemCond = ierBits[3] && modemReq;

  always_comb begin
    if (lineCond)       irqId = ID_LINE;
    else if (rxCond)    irqId = ID_RXDATA;
    else if (txCond)    irqId = ID_TXRDY;
    else if (modemCond) irqId = ID_MODEM;
    else                irqId = ID_NONE;
  end

  assign irqOut = lineCond || rxCond || txCond || modemCond;

  always_comb begin
    case (regSel)
      SEL_DATA:  regRdata = hasData ? rxHead.data : 8'h00;
      SEL_IER:   regRdata = {4'b0000, ierBits};
      SEL_IDENT: regRdata = {4'b0000, irqId};
      SEL_FCTL:  regRdata = fctlReg;
      SEL_LSR:   regRdata = lsrBits;
      default:   regRdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPushValid,
  input  logic [7:0] rxPushData,
  input  logic       rxPushPar,
  input  logic       rxPushFrm,
  input  logic       rxPushBrk,
  input  logic       txPop,
  input  logic       txShiftBusy,
  input  logic       modemReq,
  input  logic [2:0] regSel,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irqOut
);

  localparam int CW = $clog2(DEPTH + 1);

  ctlStrobe_t    strobe;
  rxEntry_t      rxPushEntry, rxHead;
  logic [CW-1:0] rxCount, rxErrCount, txCount;
  logic          rxDrop, fifoMode;
  logic [7:0]    lsrBits;
  logic [3:0]    ierBits, irqId;

  assign rxPushEntry = '{brk: rxPushBrk, frm: rxPushFrm, par: rxPushPar, data: rxPushData};

  uart_stat_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .strobe(strobe),
    .rxPushValid(rxPushValid), .rxPushEntry(rxPushEntry), .txPop(txPop),
    .rxHead(rxHead), .rxCount(rxCount), .rxErrCount(rxErrCount),
    .txCount(txCount), .rxDrop(rxDrop)
  );

  uart_stat_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .rxHead(rxHead),
    .rxCount(rxCount), .rxErrCount(rxErrCount), .txCount(txCount),
    .rxDrop(rxDrop), .txShiftBusy(txShiftBusy), .modemReq(modemReq),
    .strobe(strobe), .fifoMode(fifoMode), .lsrBits(lsrBits),
    .ierBits(ierBits), .irqId(irqId), .irqOut(irqOut)
  );

endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          rxPushValid,
  input logic          rxDrop,
  input logic          rxPop,
  input logic [CW-1:0] rxCount,
  input logic [7:0]    lsrBits,
  input logic [3:0]    ierBits,
  input logic [3:0]    irqId,
  input logic          irqOut
);

  AST_DATA_READY: assert property (@(posedge clk) disable iff (!rstN)
    rxPushValid |=> lsrBits[0]); // R1

  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rxDrop |=> lsrBits[1]); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CW'(DEPTH)); // R4

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lsrBits[7] && !rxPop && !rxPushValid) |=> lsrBits[7]); // R6

  AST_LINE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (ierBits[2] && lsrBits[7]) |-> (irqOut && irqId == ID_LINE)); // R6

  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    lsrBits[6] |-> lsrBits[5]); // R7

  AST_IDLE_ID: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (irqId == ID_NONE)); // R9

endmodule

bind uart_stat_irq uart_stat_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .rxPushValid(rxPushValid), .rxDrop(rxDrop),
  .rxPop(strobe.rxPop), .rxCount(rxCount), .lsrBits(lsrBits),
  .ierBits(ierBits), .irqId(irqId), .irqOut(irqOut)
);

// File: tb/uart_stat_irq_bench.sv
module uart_stat_irq_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxPushValid = 1'b0;
  logic [7:0] rxPushData = '0;
  logic       rxPushPar = 1'b0, rxPushFrm = 1'b0, rxPushBrk = 1'b0;
  logic       txPop = 1'b0, txShiftBusy = 1'b0, modemReq = 1'b0;
  logic [2:0] regSel = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       irqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_stat_irq u_uart_stat_irq (
    .clk(clk), .rstN(rstN), .rxPushValid(rxPushValid), .rxPushData(rxPushData),
    .rxPushPar(rxPushPar), .rxPushFrm(rxPushFrm), .rxPushBrk(rxPushBrk),
    .txPop(txPop), .txShiftBusy(txShiftBusy), .modemReq(modemReq),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] v);
    @(negedge clk); regSel = sel; regRd = 1'b1; #1 v = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk); rxPushValid = 1'b1; rxPushData = d;
    rxPushPar = p; rxPushFrm = f; rxPushBrk = b;
    @(negedge clk); rxPushValid = 1'b0; rxPushPar = 1'b0; rxPushFrm = 1'b0; rxPushBrk = 1'b0;
  endtask

  task automatic popTx(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); txPop = 1'b1;
      @(negedge clk); txPop = 1'b0;
    end
  endtask

  task automatic drain(input int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) rd(3'd0, v);
  endtask

  task automatic testReset();
    logic [7:0] v;
    chk({7'b0, irqOut}, 8'h00, "R9 irq after reset");
    rd(3'd4, v); chk(v, 8'h60, "R7 line status after reset");
    rd(3'd2, v); chk(v, 8'h01, "R9 ident after reset");
    rd(3'd1, v); chk(v, 8'h00, "R9 enable after reset");
  endtask

  task automatic testDataReady();
    logic [7:0] v;
    wr(3'd3, 8'h01);
    push(8'hA5, 1'b0, 1'b0, 1'b0);
    rd(3'd4, v); chk(v, 8'h61, "R1 ready set");
    rd(3'd0, v); chk(v, 8'hA5, "R1 data");
    rd(3'd4, v); chk(v, 8'h60, "R1 ready clear on empty");
  endtask

  task automatic testRxTrigger();
    logic [7:0] v;
    wr(3'd3, 8'h01); wr(3'd1, 8'h01);
    for (int i = 0; i < 7; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    chk({7'b0, irqOut}, 8'h00, "R2 below trigger 8");
    push(8'h07, 1'b0, 1'b0, 1'b0);
    chk({7'b0, irqOut}, 8'h01, "R2 at trigger 8");
    rd(3'd2, v); chk(v, 8'h04, "R2 ident receive");
    rd(3'd0, v);
    chk({7'b0, irqOut}, 8'h00, "R2 clears below trigger");
    drain(7);
    wr(3'd3, 8'h11);
    for (int i = 0; i < 15; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    chk({7'b0, irqOut}, 8'h00, "R11 below trigger 16");
    push(8'h0F, 1'b0, 1'b0, 1'b0);
    chk({7'b0, irqOut}, 8'h01, "R11 at trigger 16");
    drain(16);
    wr(3'd3, 8'h31);
    for (int i = 0; i < 59; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    chk({7'b0, irqOut}, 8'h00, "R11 below trigger 60");
    push(8'h3B, 1'b0, 1'b0, 1'b0);
    chk({7'b0, irqOut}, 8'h01, "R11 at trigger 60");
    drain(60);
    wr(3'd1, 8'h00);
  endtask

  task automatic testOverrun();
    logic [7:0] v;
    wr(3'd3, 8'h01);
    for (int i = 0; i < 64; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    rd(3'd4, v); chk(v, 8'h61, "R3 full without overrun");
    push(8'hEE, 1'b0, 1'b0, 1'b0);
    wr(3'd1, 8'h04);
    chk({7'b0, irqOut}, 8'h01, "R3 overrun irq");
    rd(3'd2, v); chk(v, 8'h06, "R3 overrun ident");
    rd(3'd4, v); chk(v, 8'h63, "R3 overrun flag read");
    rd(3'd4, v); chk(v, 8'h61, "R3 overrun cleared by read");
    chk({7'b0, irqOut}, 8'h00, "R3 irq drops after clear");
    for (int i = 0; i < 64; i++) begin
      rd(3'd0, v); chk(v, 8'(i), "R4 stored data unchanged");
    end
    rd(3'd4, v); chk(v, 8'h60, "R4 discarded char not stored");
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h00);
    push(8'h11, 1'b0, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b0, 1'b0);
    rd(3'd4, v); chk(v, 8'h63, "R12 single-entry overrun");
    rd(3'd0, v); chk(v, 8'h11, "R12 first char kept");
    rd(3'd4, v); chk(v, 8'h60, "R12 empty after read");
  endtask

  task automatic testErrors();
    logic [7:0] v;
    wr(3'd3, 8'h01); wr(3'd1, 8'h04);
    push(8'h01, 1'b0, 1'b0, 1'b0);
    push(8'h02, 1'b1, 1'b0, 1'b0);
    push(8'h03, 1'b0, 1'b0, 1'b0);
    push(8'h04, 1'b0, 1'b1, 1'b0);
    rd(3'd4, v); chk(v, 8'hE1, "R6 summary set, clean head");
    chk({7'b0, irqOut}, 8'h01, "R6 line irq held");
    rd(3'd2, v); chk(v, 8'h06, "R6 ident line");
    rd(3'd0, v); chk(v, 8'h01, "R5 head data");
    rd(3'd4, v); chk(v, 8'hE5, "R5 parity at head");
    rd(3'd0, v);
    rd(3'd4, v); chk(v, 8'hE1, "R6 summary kept for later entry");
    rd(3'd0, v);
    rd(3'd4, v); chk(v, 8'hE9, "R5 framing at head");
    push(8'h05, 1'b0, 1'b0, 1'b1);
    rd(3'd0, v);
    rd(3'd4, v); chk(v, 8'hF1, "R5 break at head");
    rd(3'd0, v); chk(v, 8'h05, "R5 break data");
    rd(3'd4, v); chk(v, 8'h60, "R6 summary clear when drained");
    chk({7'b0, irqOut}, 8'h00, "R6 irq clear when drained");
    wr(3'd1, 8'h00);
  endtask

  task automatic testTxStatus();
    logic [7:0] v;
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h5A);
    rd(3'd4, v); chk(v, 8'h00, "R7 tx holding full");
    @(negedge clk); txShiftBusy = 1'b1;
    popTx(1);
    rd(3'd4, v); chk(v, 8'h20, "R7 empty queue, shifter busy");
    @(negedge clk); txShiftBusy = 1'b0;
    rd(3'd4, v); chk(v, 8'h60, "R7 fully idle");
  endtask

  task automatic testTxIrq();
    logic [7:0] v;
    wr(3'd3, 8'h01); wr(3'd1, 8'h02);
    chk({7'b0, irqOut}, 8'h01, "R8 immediate on enable");
    rd(3'd2, v); chk(v, 8'h02, "R8 ident tx");
    for (int i = 0; i < 55; i++) wr(3'd0, 8'(i));
    chk({7'b0, irqOut}, 8'h01, "R8 space 9 above 8");
    wr(3'd0, 8'h00);
    chk({7'b0, irqOut}, 8'h00, "R8 space 8 not above 8");
    popTx(1);
    chk({7'b0, irqOut}, 8'h01, "R8 space back above");
    popTx(55);
    wr(3'd3, 8'h41);
    for (int i = 0; i < 47; i++) wr(3'd0, 8'(i));
    chk({7'b0, irqOut}, 8'h01, "R11 space 17 above 16");
    wr(3'd0, 8'h00);
    chk({7'b0, irqOut}, 8'h00, "R11 space 16 at tx trigger");
    popTx(48);
    wr(3'd3, 8'h00);
    chk({7'b0, irqOut}, 8'h01, "R8 non-FIFO empty holding");
    wr(3'd0, 8'h33);
    chk({7'b0, irqOut}, 8'h00, "R8 non-FIFO holding full");
    popTx(1);
    wr(3'd1, 8'h00);
  endtask

  task automatic testPriority();
    logic [7:0] v;
    wr(3'd3, 8'h01);
    @(negedge clk); modemReq = 1'b1;
    wr(3'd1, 8'h08);
    rd(3'd2, v); chk(v, 8'h00, "R10 modem alone");
    wr(3'd1, 8'h0F);
    rd(3'd2, v); chk(v, 8'h02, "R10 tx over modem");
    for (int i = 0; i < 8; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    rd(3'd2, v); chk(v, 8'h04, "R10 receive over tx");
    push(8'h08, 1'b1, 1'b0, 1'b0);
    rd(3'd2, v); chk(v, 8'h06, "R10 line over receive");
    drain(9);
    @(negedge clk); modemReq = 1'b0;
    wr(3'd1, 8'h00);
    rd(3'd2, v); chk(v, 8'h01, "R9 no cause after disable");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDataReady();
    testRxTrigger();
    testOverrun();
    testErrors();
    testTxStatus();
    testTxIrq();
    testPriority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule